// File: doc/BRIEF.md
# Paired-Channel DMA Chaining Engine

A multi-channel DMA engine that copies 32-bit words from a source address to a destination address over a simple request/acknowledge memory bus. Each word is read from the channel's current source address and then written to its current destination address. Channels are programmed through a word-addressed register port. A channel runs until its transfer count is used up. When it finishes, it clears its own run bit and can start a partner channel whose number is stored in its configuration.

A DMA write whose destination falls inside the engine's own register window goes to the engine's registers instead of the bus. This lets one channel fetch a four-word descriptor (source, destination, count, configuration) straight into a partner channel's registers. The partner then moves the data block and links back for the next descriptor. A descriptor whose link bit is clear ends the chain. Its block may target the end-of-list software interrupt register. Each channel can also be held off by peripheral request lines: one source ID, one destination ID, or both.

The transfer sequencer has four states:
- **IDLE** picks the lowest-numbered ready channel (IDLE→READ).
- **READ** holds a bus read until acknowledge. It goes READ→WRITE for a bus destination and READ→LOCAL for a destination inside the register window.
- **WRITE** holds the bus write until acknowledge (WRITE→IDLE).
- **LOCAL** performs the internal register write once the software port is not writing (LOCAL→IDLE).

Every word is one pass IDLE→READ→(WRITE|LOCAL)→IDLE, so arbitration and flow control are evaluated again before each word.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset every channel register, the status register and the mask read 0. `mem_req`, `ch_irq` and `eol_irq` are low.
- R2: Each transfer is a bus read of the current source address followed by a bus write of the read data to the current destination address. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R3: The count register (channel word offset 2) holds transfers minus one. A value of 0 moves exactly one word, and a value of N moves N+1 words.
- R4: After each word, the source address advances by 4 when configuration bit 1 is set and stays fixed otherwise. The destination address does the same under configuration bit 2.
- R5: When a block completes, the channel's run bit (configuration bit 0) clears by itself. Its count and destination read back their programmed values. Its source reads back the advanced address.
- R6: A completing channel whose link-enable bit (configuration bit 4) is 1 sets the run bit of the channel numbered in configuration bits 11:8. That channel may start on the next cycle. This set wins over a simultaneous register write. With bit 4 at 0, no other channel is started.
- R7: Block completion sets the channel's flag (status word 0x40, bit n) and its `ch_irq` bit only when configuration bit 3 is set. Writing 1 to a status bit clears it.
- R8: A write from software or from the DMA to word 0x41 sets the end-of-list flag (status bit 16). `eol_irq` is that flag unless mask word 0x42 bit 0 is set.
- R9: A DMA write whose destination has its upper 20 bits equal to the register-window base produces no bus write. Instead it writes the register at word offset `addr[11:2]`. While software is writing, the internal write waits.
- R10: Source ID (configuration bits 18:16) and destination ID (bits 22:20) of 0 mean no flow control. A nonzero ID makes each word wait until `periph_req[id]` is high.
- R11: When both IDs are nonzero, a word is started only while both named request lines are high together.
- R12: Among ready channels, the lowest channel number is served first. Arbitration happens again before every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Software register write strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| periph_req | input | 8 | Peripheral request lines, indexed by ID (line 0 unused) |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write (1) or read (0) |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data, valid with `mem_ack` |
| mem_ack | input | 1 | Bus acknowledge |
| ch_irq | output | 4 | Per-channel completion interrupt |
| eol_irq | output | 1 | End-of-list interrupt |

## Verification
The hardest situation to reach is a full descriptor chain. In it, the fetching channel's last internal write lands on the partner's configuration word in the same cycle that the fetching channel completes and links to that partner. The partner's block then finishes with a write into the end-of-list register. The stimulus programs only the fetching channel. It places two descriptors in bench memory: a two-word data move that links back, and a one-word move into the end-of-list register with linking cleared. The bench then checks the following:
- the partner's bus writes;
- that no bus write reaches the register window;
- the final register contents;
- the raised end-of-list interrupt.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int WORD_W  = 32;
    localparam int LINK_W  = 4;
    localparam int ID_W    = 3;
    localparam int NREQ    = 1 << ID_W;
    localparam int RADDR_W = 10;

    // channel configuration word
    typedef struct packed {
        logic [8:0]        rsv_hi;
        logic [ID_W-1:0]   dst_id;
        logic              rsv_b19;
        logic [ID_W-1:0]   src_id;
        logic [3:0]        rsv_mid;
        logic [LINK_W-1:0] link_ch;
        logic [2:0]        rsv_lo;
        logic              link_en;
        logic              irq_en;
        logic              dst_inc;
        logic              src_inc;
        logic              run;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_LOCAL
    } seq_state_t;

    // register word offsets inside a channel
    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CFG = 2'd3;

    // global register word addresses
    localparam logic [RADDR_W-1:0] W_STATUS = 10'h040;
    localparam logic [RADDR_W-1:0] W_SWI    = 10'h041;
    localparam logic [RADDR_W-1:0] W_MASK   = 10'h042;
    localparam int EOL_BIT = 16;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chain_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              step,
    input  logic              link_set,
    output logic [WORD_W-1:0] cur_src,
    output logic [WORD_W-1:0] cur_dst,
    output logic [LEN_W-1:0]  remaining,
    output chan_cfg_t         cfg,
    output logic              done
);

    localparam logic [WORD_W-1:0] STRIDE = WORD_W'(4);

    logic [WORD_W-1:0] src_q, dst_q, dst_base;
    logic [LEN_W-1:0]  cnt_q, cnt_base;
    chan_cfg_t         cfg_q;

    logic wr_src, wr_dst, wr_cnt, wr_cfg;

    assign wr_src = wr_en && (wr_sel == SEL_SRC);
    assign wr_dst = wr_en && (wr_sel == SEL_DST);
    assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
    assign wr_cfg = wr_en && (wr_sel == SEL_CFG);

    assign done = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            dst_base <= '0;
            cnt_q    <= '0;
            cnt_base <= '0;
            cfg_q    <= '0;
        end else begin
            if (wr_src) begin
                src_q <= wr_data;
            end else if (step && cfg_q.src_inc) begin
                src_q <= src_q + STRIDE;
            end

            if (wr_dst) begin
                dst_base <= wr_data;
                dst_q    <= wr_data;
            end else if (done) begin
                dst_q <= dst_base;
            end else if (step && cfg_q.dst_inc) begin
                dst_q <= dst_q + STRIDE;
            end

            if (wr_cnt) begin
                cnt_base <= wr_data[LEN_W-1:0];
                cnt_q    <= wr_data[LEN_W-1:0];
            end else if (done) begin
                cnt_q <= cnt_base;
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (wr_cfg) begin
                cfg_q <= chan_cfg_t'(wr_data);
            end else if (done) begin
                cfg_q.run <= 1'b0;
            end
            if (link_set) begin
                cfg_q.run <= 1'b1;
            end
        end
    end

    assign cur_src   = src_q;
    assign cur_dst   = dst_q;
    assign remaining = cnt_q;
    assign cfg       = cfg_q;

endmodule

// File: rtl/dma_pick.sv
module dma_pick
    import dma_chain_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  run,
    input  logic [ID_W-1:0] src_id [NCH],
    input  logic [ID_W-1:0] dst_id [NCH],
    input  logic [NREQ-1:0] periph_req,
    output logic [NCH-1:0]  ready,
    output logic            grant_vld,
    output logic [CH_W-1:0] grant_ch
);

    for (genvar k = 0; k < NCH; k++) begin : g_ready
        logic src_ok, dst_ok;
        assign src_ok   = (src_id[k] == '0) || periph_req[src_id[k]];
        assign dst_ok   = (dst_id[k] == '0) || periph_req[dst_id[k]];
        assign ready[k] = run[k] && src_ok && dst_ok;
    end

    // lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        grant_vld = 1'b0;
        grant_ch  = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (ready[k]) begin
                grant_vld = 1'b1;
                grant_ch  = CH_W'(k);
            end
        end
    end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_chain_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grant_vld,
    input  logic [CH_W-1:0]    grant_ch,
    input  logic [WORD_W-1:0]  src_addr,
    input  logic [WORD_W-1:0]  dst_addr,
    input  logic               dst_local,
    input  logic               sw_busy,
    input  logic               mem_ack,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic [CH_W-1:0]    cur_ch,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               step,
    output logic               loc_we,
    output logic [RADDR_W-1:0] loc_addr,
    output logic [WORD_W-1:0]  loc_wdata
);

    seq_state_t        state_q, state_d;
    logic [CH_W-1:0]   ch_q;
    logic [WORD_W-1:0] data_q;

    // state register and datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && grant_vld) begin
                ch_q <= grant_ch;
            end
            if (state_q == S_READ && mem_ack) begin
                data_q <= mem_rdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (grant_vld) state_d = S_READ;
            S_READ:  if (mem_ack)   state_d = dst_local ? S_LOCAL : S_WRITE;
            S_WRITE: if (mem_ack)   state_d = S_IDLE;
            S_LOCAL: if (!sw_busy)  state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_addr;
        step      = 1'b0;
        loc_we    = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_READ: begin
                mem_req = 1'b1;
            end
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_addr;
                step     = mem_ack;
            end
            S_LOCAL: begin
                loc_we = !sw_busy;
                step   = !sw_busy;
            end
            default: ;
        endcase
    end

    assign mem_wdata = data_q;
    assign loc_addr  = dst_addr[11:2];
    assign loc_wdata = data_q;
    assign cur_ch    = ch_q;

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int          NCH      = 4,
    parameter int          LEN_W    = 16,
    parameter logic [31:0] REG_BASE = 32'hFFFF_F000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic [NREQ-1:0]    periph_req,
    output logic               mem_req,
    output logic               mem_we,
    output logic [WORD_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic [NCH-1:0]     ch_irq,
    output logic               eol_irq
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    // per-channel views
    logic [WORD_W-1:0] src_a [NCH];
    logic [WORD_W-1:0] dst_a [NCH];
    logic [LEN_W-1:0]  cnt_a [NCH];
    logic [ID_W-1:0]   sid_a [NCH];
    logic [ID_W-1:0]   did_a [NCH];
    chan_cfg_t [NCH-1:0] cfg_a;
    logic [NCH-1:0] run_v, done_a, step_a, link_a, wr_a, irq_set, ready_v;

    // sequencer wiring
    logic               grant_vld, seq_step, loc_we, dst_local;
    logic [CH_W-1:0]    grant_ch, cur_ch;
    logic [RADDR_W-1:0] loc_addr;
    logic [WORD_W-1:0]  loc_wdata;

    // merged register write port
    logic               eff_we;
    logic [RADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0]  eff_data;

    logic [NCH-1:0] ch_flag_q;
    logic           eol_q, eol_mask_q;
    logic           status_wr, swi_hit;

    assign eff_we   = reg_we || loc_we;
    assign eff_addr = reg_we ? reg_addr  : loc_addr;
    assign eff_data = reg_we ? reg_wdata : loc_wdata;

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        assign wr_a[k]   = eff_we && (eff_addr[9:6] == 4'h0) && (eff_addr[5:2] == 4'(k));
        assign step_a[k] = seq_step && (cur_ch == CH_W'(k));

        dma_chan_regs #(.LEN_W(LEN_W)) i_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_a[k]),
            .wr_sel    (eff_addr[1:0]),
            .wr_data   (eff_data),
            .step      (step_a[k]),
            .link_set  (link_a[k]),
            .cur_src   (src_a[k]),
            .cur_dst   (dst_a[k]),
            .remaining (cnt_a[k]),
            .cfg       (cfg_a[k]),
            .done      (done_a[k])
        );

        assign run_v[k]   = cfg_a[k].run;
        assign sid_a[k]   = cfg_a[k].src_id;
        assign did_a[k]   = cfg_a[k].dst_id;
        assign irq_set[k] = done_a[k] && cfg_a[k].irq_en;
    end

    // partner enables from completing channels
    always_comb begin
        link_a = '0;
        for (int j = 0; j < NCH; j++) begin
            for (int k = 0; k < NCH; k++) begin
                if (done_a[j] && cfg_a[j].link_en && (cfg_a[j].link_ch == LINK_W'(k))) begin
                    link_a[k] = 1'b1;
                end
            end
        end
    end

    dma_pick #(.NCH(NCH), .CH_W(CH_W)) i_pick (
        .run        (run_v),
        .src_id     (sid_a),
        .dst_id     (did_a),
        .periph_req (periph_req),
        .ready      (ready_v),
        .grant_vld  (grant_vld),
        .grant_ch   (grant_ch)
    );

    assign dst_local = (dst_a[cur_ch][31:12] == REG_BASE[31:12]);

    dma_seq #(.CH_W(CH_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vld (grant_vld),
        .grant_ch  (grant_ch),
        .src_addr  (src_a[cur_ch]),
        .dst_addr  (dst_a[cur_ch]),
        .dst_local (dst_local),
        .sw_busy   (reg_we),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .cur_ch    (cur_ch),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .step      (seq_step),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata)
    );

    // interrupt flags
    assign status_wr = eff_we && (eff_addr == W_STATUS);
    assign swi_hit   = eff_we && (eff_addr == W_SWI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_flag_q  <= '0;
            eol_q      <= 1'b0;
            eol_mask_q <= 1'b0;
        end else begin
            if (status_wr) begin
                ch_flag_q <= (ch_flag_q & ~eff_data[NCH-1:0]) | irq_set;
            end else begin
                ch_flag_q <= ch_flag_q | irq_set;
            end
            if (swi_hit) begin
                eol_q <= 1'b1;
            end else if (status_wr && eff_data[EOL_BIT]) begin
                eol_q <= 1'b0;
            end
            if (eff_we && (eff_addr == W_MASK)) begin
                eol_mask_q <= eff_data[0];
            end
        end
    end

    assign ch_irq  = ch_flag_q;
    assign eol_irq = eol_q && !eol_mask_q;

    // register read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[9:6] == 4'h0) begin
            for (int k = 0; k < NCH; k++) begin
                if (reg_addr[5:2] == 4'(k)) begin
                    unique case (reg_addr[1:0])
                        SEL_SRC: reg_rdata = src_a[k];
                        SEL_DST: reg_rdata = dst_a[k];
                        SEL_CNT: reg_rdata = WORD_W'(cnt_a[k]);
                        SEL_CFG: reg_rdata = cfg_a[k];
                        default: reg_rdata = '0;
                    endcase
                end
            end
        end else if (reg_addr == W_STATUS) begin
            reg_rdata[NCH-1:0] = ch_flag_q;
            reg_rdata[EOL_BIT] = eol_q;
        end else if (reg_addr == W_MASK) begin
            reg_rdata[0] = eol_mask_q;
        end
    end

endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk #(
    parameter int          NCH      = 4,
    parameter logic [31:0] REG_BASE = 32'hFFFF_F000
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ack,
    input logic [31:12]   mem_page,
    input logic [NCH-1:0] ch_irq,
    input logic           eol_irq,
    input logic           eol_mask,
    input logic           swi_hit,
    input logic           step
);

    // R2
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_page)));

    // R2
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ack));

    // R9
    local_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_page != REG_BASE[31:12]));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ch_irq & ~$past(ch_irq))) |-> $past(step));

    // R8
    swi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swi_hit |=> (eol_irq || eol_mask));

endmodule

bind dma_chain_engine dma_chain_chk #(.NCH(NCH), .REG_BASE(REG_BASE)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_page (mem_addr[31:12]),
    .ch_irq   (ch_irq),
    .eol_irq  (eol_irq),
    .eol_mask (eol_mask_q),
    .swi_hit  (swi_hit),
    .step     (seq_step)
);

// File: tb/test_dma_chain_engine.sv
`timescale 1ns/1ps
module test_dma_chain_engine;

    localparam logic [31:0] WIN = 32'hFFFF_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  periph_req = '0;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  ch_irq;
    logic        eol_irq;

    logic [31:0] mem [0:1023];
    logic        stall_en = 1'b0;
    logic [1:0]  scnt = '0;
    int total = 0, bad = 0, bus_writes = 0, bus_reads = 0;
    bit finished = 0;

    typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t expq [$];

    always #4 clk = ~clk;
    always @(posedge clk) scnt <= scnt + 2'd1;

    assign mem_ack   = mem_req && !(stall_en && scnt == 2'd0);
    assign mem_rdata = mem[mem_addr[11:2]];

    dma_chain_engine i_dma_chain_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .ch_irq(ch_irq), .eol_irq(eol_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // driver: predict the bus writes of one block
    task automatic expect_block(input logic [31:0] src, input logic [31:0] dst,
                                input int cnt, input bit sinc, input bit dinc);
        for (int i = 0; i <= cnt; i++) begin
            logic [31:0] s, d;
            wr_t e;
            s = sinc ? src + 32'(4 * i) : src;
            d = dinc ? dst + 32'(4 * i) : dst;
            e.a = d; e.d = mem[s[11:2]];
            expq.push_back(e);
        end
    endtask

    task automatic wait_run_clear(input int ch, input string tag);
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(10'(ch * 4 + 3), v);
            if (v[0] == 1'b0) return;
        end
        chk({tag, " run timeout"}, 32'd1, 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: compare bus writes against the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                bus_writes++;
                mem[mem_addr[11:2]] = mem_wdata;
                if (expq.size() == 0) begin
                    chk("R2,R12 unexpected write addr", mem_addr, 32'hxxxx_xxxx);
                end else begin
                    wr_t e;
                    e = expq.pop_front();
                    chk("R2,R12 write addr", mem_addr, e.a);
                    chk("R2 write data", mem_wdata, e.d);
                end
            end else begin
                bus_reads++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int w0, r0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A00_0000 ^ (i * 32'h0001_0003);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'h003, v); chk("R1 ch0 cfg", v, 0);
        rd(10'h008, v); chk("R1 ch2 src", v, 0);
        rd(10'h040, v); chk("R1 status", v, 0);
        rd(10'h042, v); chk("R1 mask", v, 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 irqs", {27'd0, ch_irq, eol_irq}, 0);

        // block of 4 words, both increments, irq enabled, bus stalls
        stall_en = 1'b1;
        w0 = bus_writes;
        wr(10'h008, 32'h100); wr(10'h009, 32'h200); wr(10'h00A, 32'd3);
        expect_block(32'h100, 32'h200, 3, 1, 1);
        wr(10'h00B, 32'h0000_000F);
        wait_run_clear(2, "R5");
        repeat (3) @(negedge clk);
        chk("R3 four words", 32'(bus_writes - w0), 4);
        chk("R3 queue empty", 32'(expq.size()), 0);
        rd(10'h008, v); chk("R4 src advanced", v, 32'h110);
        rd(10'h009, v); chk("R5 dst reloaded", v, 32'h200);
        rd(10'h00A, v); chk("R5 count reloaded", v, 32'd3);
        rd(10'h00B, v); chk("R5 run cleared", v, 32'h0000_000E);
        chk("R7 ch_irq set", 32'(ch_irq), 32'h4);
        rd(10'h040, v); chk("R7 status", v, 32'h4);
        wr(10'h040, 32'h4);
        @(negedge clk);
        chk("R7 w1c", 32'(ch_irq), 0);
        stall_en = 1'b0;

        // single word, fixed addresses, irq disabled
        w0 = bus_writes;
        wr(10'h00C, 32'h300); wr(10'h00D, 32'h304); wr(10'h00E, 32'd0);
        expect_block(32'h300, 32'h304, 0, 0, 0);
        wr(10'h00F, 32'h0000_0001);
        wait_run_clear(3, "R3");
        repeat (3) @(negedge clk);
        chk("R3 one word", 32'(bus_writes - w0), 1);
        rd(10'h00C, v); chk("R4 src fixed", v, 32'h300);
        chk("R7 silent", 32'(ch_irq), 0);
        rd(10'h040, v); chk("R7 status silent", v, 0);

        // gated channels, priority order once released
        r0 = bus_reads;
        wr(10'h004, 32'h140); wr(10'h005, 32'h500); wr(10'h006, 32'd1);
        wr(10'h007, 32'h0001_0007);
        wr(10'h000, 32'h180); wr(10'h001, 32'h400); wr(10'h002, 32'd1);
        wr(10'h003, 32'h0001_0007);
        expect_block(32'h180, 32'h400, 1, 1, 1);
        expect_block(32'h140, 32'h500, 1, 1, 1);
        repeat (20) @(negedge clk);
        chk("R10 gated no reads", 32'(bus_reads - r0), 0);
        periph_req[1] = 1'b1;
        wait_run_clear(1, "R12");
        repeat (3) @(negedge clk);
        chk("R12 queue drained in order", 32'(expq.size()), 0);
        periph_req = '0;

        // two request lines must both be high
        r0 = bus_reads; w0 = bus_writes;
        wr(10'h000, 32'h1C0); wr(10'h001, 32'h480); wr(10'h002, 32'd0);
        wr(10'h003, 32'h0032_0001);
        periph_req = 8'b0000_0100;
        repeat (20) @(negedge clk);
        chk("R11 src only", 32'(bus_reads - r0), 0);
        periph_req = 8'b0000_1000;
        repeat (20) @(negedge clk);
        chk("R11 dst only", 32'(bus_reads - r0), 0);
        expect_block(32'h1C0, 32'h480, 0, 0, 0);
        periph_req = 8'b0000_1100;
        wait_run_clear(0, "R11");
        repeat (3) @(negedge clk);
        chk("R11 both moved one", 32'(bus_writes - w0), 1);
        periph_req = '0;

        // descriptor chain ending in the end-of-list register
        mem[384] = 32'h700; mem[385] = 32'h800; mem[386] = 32'd1; mem[387] = 32'h16;
        mem[388] = 32'h710; mem[389] = WIN + 32'h104; mem[390] = 32'd0; mem[391] = 32'h2;
        expect_block(32'h700, 32'h800, 1, 1, 1);
        w0 = bus_writes;
        wr(10'h000, 32'h600); wr(10'h001, WIN + 32'h10); wr(10'h002, 32'd3);
        wr(10'h003, 32'h0000_0117);
        for (int i = 0; i < 3000 && !eol_irq; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R8 eol raised by DMA", 32'(eol_irq), 1);
        chk("R9 only data writes on bus", 32'(bus_writes - w0), 2);
        chk("R9 queue empty", 32'(expq.size()), 0);
        rd(10'h007, v); chk("R6 R9 ch1 cfg from descriptor", v, 32'h2);
        rd(10'h004, v); chk("R6 second block ran", v, 32'h714);
        rd(10'h003, v); chk("R6 chain stopped", v, 32'h116);
        rd(10'h000, v); chk("R5 fetch src advanced", v, 32'h620);
        rd(10'h040, v); chk("R8 status eol bit", v, 32'h0001_0000);

        // mask and software raise
        wr(10'h042, 32'h1);
        @(negedge clk);
        chk("R8 masked", 32'(eol_irq), 0);
        wr(10'h042, 32'h0);
        @(negedge clk);
        chk("R8 unmasked", 32'(eol_irq), 1);
        wr(10'h040, 32'h0001_0000);
        @(negedge clk);
        chk("R8 cleared", 32'(eol_irq), 0);
        wr(10'h041, 32'h0);
        @(negedge clk);
        chk("R8 software raise", 32'(eol_irq), 1);

        finish_run();
    end

endmodule